// File: doc/BRIEF.md
# Up/Down Compare Timer

This block is a programmable counter that counts externally supplied enable ticks either upward or downward, wrapping at its width. Software sets it up through a small byte-wide write port: a control byte, a load value written as separate bytes, a match-action byte and a compare value, also written as separate bytes. Writing the control byte can zero the counter or copy the load value into it in a single step.

When a counting step lands on the compare value, the block raises a one-cycle interrupt pulse and sets a sticky equal flag. The flag stays set until a status-read strobe clears it. The match-action byte selects what happens to the counter after a match: it can be restored to the load value, zeroed, or left to keep counting.

Top module: `updown_cmp_timer`

## Requirements
- R1: After reset the count, the equal flag and the interrupt are all zero, and every internal register (enable, direction, match actions, load value, compare value) is zero.
- R2: Write map (the counter is 3 bytes wide by default). Address 0 is control, address 1 is match action, addresses 2..4 hold the load value least significant byte first, and addresses 5..7 hold the compare value least significant byte first. A write changes only the addressed byte.
- R3: When enable is set and up is set, each cycle with `tick_i` high adds one to the count. The count wraps from all ones to zero.
- R4: When enable is set and up is clear, each tick subtracts one from the count. The count wraps from zero to all ones.
- R5: While enable is clear, ticks leave the count unchanged.
- R6: Writing control with bit 1 (clear) set zeroes the count on that write. Clear wins over bit 2 (load).
- R7: Writing control with bit 2 (load) set and bit 1 clear copies the stored load value into the count. The same write stores bit 0 as enable and bit 3 as up.
- R8: A match occurs when a counting step produces a value equal to the compare value. A match gives a one-cycle `irq_o` pulse in the cycle after the step, and `eq_o` is set from that cycle onward.
- R9: On a match with match-action bit 0 (reload) set, the count takes the load value. Reload wins over bit 1.
- R10: On a match with reload clear and match-action bit 1 (clear-on-match) set, the count becomes zero.
- R11: On a match with both action bits clear, the count holds the compare value and counting continues from there.
- R12: `eq_o` stays set until a cycle with `stat_rd_i` high clears it. When a match and a status read happen in the same cycle, the flag stays set.
- R13: In a cycle that writes control, a tick does not step the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable tick, one step per high cycle |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 3 | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| stat_rd_i | input | 1 | Status read strobe; clears the equal flag |
| count_o | output | 24 | Current count |
| eq_o | output | 1 | Sticky equal flag |
| irq_o | output | 1 | One-cycle match interrupt pulse |

## Verification
The bench builds the block with its default 24-bit width, which gives three byte lanes per value and a 3-bit address. Because both wrap points are reached by loading values next to them, the 2^24 rollover upward and the underflow below zero can be tested in a few ticks rather than millions. With the same width, matches are reached in a handful of ticks under each match action, including a match that lands in the same cycle as a status read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // control byte bit positions
    localparam int CTL_EN  = 0;
    localparam int CTL_CLR = 1;
    localparam int CTL_LD  = 2;
    localparam int CTL_UP  = 3;
    // match-action byte bit positions
    localparam int ACT_RELOAD = 0;
    localparam int ACT_ZERO   = 1;
    // fixed addresses; value lanes follow
    localparam int ADR_CTL = 0;
    localparam int ADR_ACT = 1;
    localparam int ADR_LD0 = 2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic              en_o,
    output logic              up_o,
    output logic              reload_o,
    output logic              zero_o,
    output logic [CNT_W-1:0]  ld_val_o,
    output logic [CNT_W-1:0]  cmp_val_o,
    output logic              ctl_wr_o,
    output logic              ctl_clr_o,
    output logic              ctl_ld_o
);
    localparam int NLANE   = CNT_W / BYTE_W;
    localparam int CMP_LD0 = ADR_LD0 + NLANE;

    typedef struct packed {
        logic             en;
        logic             up;
        logic             reload;
        logic             zero;
        logic [CNT_W-1:0] ld;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t r_d, r_q;

    logic ctl_hit;
    assign ctl_hit = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CTL));

    always_comb begin
        r_d = r_q;
        if (ctl_hit) begin
            r_d.en = wr_data_i[CTL_EN];
            r_d.up = wr_data_i[CTL_UP];
        end
        if (wr_en_i && (wr_addr_i == ADDR_W'(ADR_ACT))) begin
            r_d.reload = wr_data_i[ACT_RELOAD];
            r_d.zero   = wr_data_i[ACT_ZERO];
        end
        for (int b = 0; b < NLANE; b++) begin
            if (wr_en_i && (wr_addr_i == ADDR_W'(ADR_LD0 + b)))
                r_d.ld[b*BYTE_W +: BYTE_W] = wr_data_i;
            if (wr_en_i && (wr_addr_i == ADDR_W'(CMP_LD0 + b)))
                r_d.cmp[b*BYTE_W +: BYTE_W] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_o      = r_q.en;
    assign up_o      = r_q.up;
    assign reload_o  = r_q.reload;
    assign zero_o    = r_q.zero;
    assign ld_val_o  = r_q.ld;
    assign cmp_val_o = r_q.cmp;
    assign ctl_wr_o  = ctl_hit;
    assign ctl_clr_o = wr_data_i[CTL_CLR];
    assign ctl_ld_o  = wr_data_i[CTL_LD];

    // R2: a write to the match-action address leaves the compare value alone
    p_act_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(ADR_ACT)) |=> $stable(cmp_val_o));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             up_i,
    input  logic             reload_i,
    input  logic             zero_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             ctl_wr_i,
    input  logic             ctl_clr_i,
    input  logic             ctl_ld_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_t;

    core_t c_d, c_q;
    logic [CNT_W-1:0] step;
    logic             hit;
    logic             stepping;

    always_comb begin
        c_d      = c_q;
        hit      = 1'b0;
        stepping = tick_i && en_i && !ctl_wr_i;
        step     = up_i ? c_q.cnt + CNT_W'(1) : c_q.cnt - CNT_W'(1);
        if (ctl_wr_i) begin
            if (ctl_clr_i)     c_d.cnt = '0;
            else if (ctl_ld_i) c_d.cnt = ld_val_i;
        end else if (stepping) begin
            c_d.cnt = step;
            if (step == cmp_val_i) begin
                hit = 1'b1;
                if (reload_i)    c_d.cnt = ld_val_i;
                else if (zero_i) c_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_o   = c_q.cnt;
    assign match_o = hit;

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_i && !(tick_i && en_i)) |=> $stable(cnt_o));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && ctl_clr_i) |=> (cnt_o == '0));
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && !ctl_clr_i && ctl_ld_i) |=> (cnt_o == $past(ld_val_i)));
    p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_i && tick_i && en_i && up_i && !match_o)
        |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))));
    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && reload_i) |=> (cnt_o == $past(ld_val_i)));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic stat_rd_i,
    output logic eq_o,
    output logic irq_o
);
    typedef struct packed {
        logic eq;
        logic irq;
    } flag_t;

    flag_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.irq = match_i;
        if (match_i)        f_d.eq = 1'b1;
        else if (stat_rd_i) f_d.eq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign eq_o  = f_q.eq;
    assign irq_o = f_q.irq;

    p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> eq_o);
    p_match_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> (irq_o && eq_o));
    p_rd_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !match_i) |=> !eq_o);
endmodule

// File: rtl/updown_cmp_timer.sv
module updown_cmp_timer #(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     tick_i,
    input  logic                                     wr_en_i,
    input  logic [$clog2(2+2*(CNT_W/BYTE_W))-1:0]    wr_addr_i,
    input  logic [BYTE_W-1:0]                        wr_data_i,
    input  logic                                     stat_rd_i,
    output logic [CNT_W-1:0]                         count_o,
    output logic                                     eq_o,
    output logic                                     irq_o
);
    localparam int NLANE  = CNT_W / BYTE_W;
    localparam int ADDR_W = $clog2(2 + 2*NLANE);

    logic             en, up, reload, zero;
    logic [CNT_W-1:0] ld_val, cmp_val;
    logic             ctl_wr, ctl_clr, ctl_ld;
    logic             match;
    logic             unused_hi;

    assign unused_hi = ^wr_data_i[BYTE_W-1:4];

    tmr_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .en_o(en), .up_o(up), .reload_o(reload), .zero_o(zero),
        .ld_val_o(ld_val), .cmp_val_o(cmp_val),
        .ctl_wr_o(ctl_wr), .ctl_clr_o(ctl_clr), .ctl_ld_o(ctl_ld)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .en_i(en), .up_i(up), .reload_i(reload), .zero_i(zero),
        .ld_val_i(ld_val), .cmp_val_i(cmp_val),
        .ctl_wr_i(ctl_wr), .ctl_clr_i(ctl_clr), .ctl_ld_i(ctl_ld),
        .cnt_o(count_o), .match_o(match)
    );

    tmr_flag u_flag (
        .clk(clk), .rst_n(rst_n), .match_i(match), .stat_rd_i(stat_rd_i),
        .eq_o(eq_o), .irq_o(irq_o)
    );

    // R13: a control write never produces a match in that cycle
    p_ctl_no_match_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |-> !match);
endmodule

// File: tb/tb_updown_cmp_timer.sv
module tb_updown_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, we = 1'b0, rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  data = '0;
    logic [23:0] count;
    logic        eq, irq;

    int total = 0, bad = 0;
    bit finished = 0;

    // behavioural reference state
    logic [23:0] m_cnt = 0, m_ld = 0, m_cmp = 0;
    bit m_en = 0, m_up = 0, m_rl = 0, m_cl = 0, m_eq = 0, m_irq = 0;

    always #10 clk = ~clk;

    updown_cmp_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(we),
        .wr_addr_i(addr), .wr_data_i(data), .stat_rd_i(rd),
        .count_o(count), .eq_o(eq), .irq_o(irq)
    );

    task automatic check(input string tag);
        total++;
        if (count !== m_cnt || eq !== m_eq || irq !== m_irq) begin
            bad++;
            $display("FAIL %s: count=%h eq=%b irq=%b expected count=%h eq=%b irq=%b",
                     tag, count, eq, irq, m_cnt, m_eq, m_irq);
        end
    endtask

    task automatic model(input bit t, input bit w, input logic [2:0] a,
                         input logic [7:0] d, input bit r);
        bit hit = 0;
        logic [23:0] nx;
        if (w && a == 3'd0) begin
            if (d[1])      m_cnt = 0;
            else if (d[2]) m_cnt = m_ld;
        end else if (t && m_en) begin
            nx = m_up ? m_cnt + 24'd1 : m_cnt - 24'd1;
            if (nx == m_cmp) begin
                hit = 1;
                m_cnt = m_rl ? m_ld : (m_cl ? 24'd0 : nx);
            end else m_cnt = nx;
        end
        if (w) begin
            case (a)
                3'd0: begin m_en = d[0]; m_up = d[3]; end
                3'd1: begin m_rl = d[0]; m_cl = d[1]; end
                3'd2: m_ld[7:0]   = d;
                3'd3: m_ld[15:8]  = d;
                3'd4: m_ld[23:16] = d;
                3'd5: m_cmp[7:0]   = d;
                3'd6: m_cmp[15:8]  = d;
                default: m_cmp[23:16] = d;
            endcase
        end
        m_irq = hit;
        if (hit) m_eq = 1;
        else if (r) m_eq = 0;
    endtask

    task automatic step(input bit t, input bit w, input logic [2:0] a,
                        input logic [7:0] d, input bit r, input string tag);
        tick = t; we = w; addr = a; data = d; rd = r;
        @(posedge clk);
        model(t, w, a, d, r);
        @(negedge clk);
        tick = 0; we = 0; rd = 0;
        check(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        step(0, 1, a, d, 0, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 3'd0, 8'd0, 0, tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset");
        // R2: byte lanes of load and compare
        wr(3'd2, 8'h05, "R2"); wr(3'd3, 8'h00, "R2"); wr(3'd4, 8'h00, "R2");
        wr(3'd5, 8'h00, "R2"); wr(3'd6, 8'h01, "R2"); wr(3'd7, 8'h00, "R2");
        wr(3'd0, 8'b1101, "R7 load up enable");
        ticks(3, "R3 up count");
        step(0, 0, 3'd0, 8'd0, 0, "R5 no tick");
        wr(3'd0, 8'b1000, "R5 disable");
        ticks(2, "R5 hold while disabled");
        wr(3'd0, 8'b0110, "R6 clear beats load");
        wr(3'd0, 8'b0001, "R4 down enable");
        ticks(2, "R4 down wrap");
        step(1, 1, 3'd0, 8'b0001, 0, "R13 tick during control write");
        wr(3'd2, 8'hFE, "R2"); wr(3'd3, 8'hFF, "R2"); wr(3'd4, 8'hFF, "R2");
        wr(3'd0, 8'b1101, "R7 load near top");
        ticks(2, "R3 up wrap");
        // match handling
        wr(3'd5, 8'h03, "R2"); wr(3'd6, 8'h00, "R2"); wr(3'd7, 8'h00, "R2");
        ticks(3, "R8 match pulse");
        ticks(1, "R11 keep counting");
        step(0, 0, 3'd0, 8'd0, 0, "R12 sticky");
        step(0, 0, 3'd0, 8'd0, 0, "R12 sticky");
        step(0, 0, 3'd0, 8'd0, 1, "R12 read clears");
        wr(3'd1, 8'h03, "R9 reload and zero");
        wr(3'd2, 8'h01, "R2"); wr(3'd3, 8'h00, "R2"); wr(3'd4, 8'h00, "R2");
        wr(3'd0, 8'b1101, "R7");
        ticks(2, "R9 reload on match");
        ticks(1, "R9");
        step(1, 0, 3'd0, 8'd0, 1, "R12 match beats read");
        step(0, 0, 3'd0, 8'd0, 1, "R12 read clears");
        wr(3'd1, 8'h02, "R10 zero on match");
        ticks(3, "R10 zero on match");
        ticks(1, "R10 after zero");
        wr(3'd1, 8'h00, "R11");
        wr(3'd0, 8'b0101, "R4 load down");
        ticks(3, "R4 down after load");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule